// File: doc/BRIEF.md
# I2C Target Controller with Bus-Event Status Flags

This block is an I2C target (slave) on a single bus. SDA and SCL come in through two-flop synchronisers. The block detects START, repeated START and STOP. It matches the 7-bit address against a programmable own address and also recognises the general call address. It acknowledges on the ninth clock, then either receives bytes into a receive holding register or sends bytes from a transmit holding register. SDA is open-drain: the block only ever pulls it low.

A host writes the transmit holding register with a one-cycle strobe, reads the receive holding register with a one-cycle strobe, and watches a six-bit status word. The bits in that word set and clear on bus events, not on host writes. The block does not stretch the clock, does not use 10-bit addresses, and never acts as bus master.

Status word bit positions: [0] done, [1] rx-ready, [2] tx-ready, [3] direction (1 = master read), [4] addressed, [5] general call.

Top module: `i2c_target_stat`

## Requirements
- R1: After reset the status word is 6'b000101 (done and tx-ready set, all others clear), and `sda_oe` is 0.
- R2: The done flag clears when a START (SDA falling while SCL high) is seen, and sets when a STOP (SDA rising while SCL high) is seen.
- R3: When an address byte's upper seven bits equal `own_addr`, the target pulls SDA low on the ninth clock and sets the addressed flag. It also sets the direction flag to the byte's LSB (1 = master read).
- R4: A non-matching address is not acknowledged and leaves the addressed flag clear. When such an address follows a repeated START, the addressed flag clears and the done flag sets.
- R5: An address byte of 8'h00 sets the general-call flag and is acknowledged. The following bytes are received while the addressed flag stays 0. The general-call flag clears at STOP.
- R6: In a write transfer each byte is shifted in MSB first and copied to `rx_data`. The rx-ready flag sets and the target acknowledges that byte on the ninth clock.
- R7: A `rx_rd` strobe clears the rx-ready flag.
- R8: A `tx_wr` strobe loads `tx_data` and clears tx-ready. Tx-ready sets again only after that byte has been sent and the master has answered with ACK or NACK.
- R9: In a read transfer the target sends the loaded byte MSB first. If no byte is loaded, it sends 8'hFF.
- R10: When the master answers a sent byte with NACK, the addressed flag clears and the target stops sending. A byte written after that stays loaded with tx-ready low, and is sent in the next read transfer.
- R11: A STOP clears the addressed flag.
- R12: The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Programmed own address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| tx_wr | input | 1 | Strobe that loads `tx_data` into the transmit holding register |
| tx_data | input | 8 | Byte to send |
| rx_rd | input | 1 | Strobe that marks the receive holding register as read |
| rx_data | output | 8 | Receive holding register |
| status | output | 6 | Status flags (bit positions given above) |

## Verification
The checks take four things for granted about the inputs:
- SCL stays low for several clocks after each falling edge, longer than the synchroniser delay, before the master moves SDA.
- The master issues START or STOP only while the target has released SDA.
- The host strobes `rx_rd` only after rx-ready is set, and never in the cycle a byte lands.
- The host strobes `tx_wr` only between transfers.

The bench master keeps to all four:
- It holds every SCL quarter-period for five clocks.
- It places START and STOP only after the acknowledge clock has finished.
- Its monitor reads only in response to a set rx-ready flag.
- Its transmit writes fall only where SCL is idle or held low.

// File: rtl/i2c_target_stat.sv
module i2c_target_stat #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_data,
  output logic [5:0]    status
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, thr, rx_hold;
  logic thr_full, host_byte, mack, in_frame, rep;
  logic rxrdy, txrdy, access, dir, gcall, done;

  wire [DW-1:0] nb = thr_full ? thr : '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; shreg <= '0; thr <= '0; rx_hold <= '0;
      thr_full <= 1'b0; host_byte <= 1'b0; mack <= 1'b0; in_frame <= 1'b0; rep <= 1'b0;
      rxrdy <= 1'b0; txrdy <= 1'b1; access <= 1'b0; dir <= 1'b0; gcall <= 1'b0;
      done <= 1'b1; sda_oe <= 1'b0;
    end else begin
      if (rx_rd) rxrdy <= 1'b0;
      if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0; access <= 1'b0; gcall <= 1'b0;
        done <= 1'b1; in_frame <= 1'b0;
      end else if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; done <= 1'b0;
        rep <= in_frame; in_frame <= 1'b1;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(DW)) begin
              if (shreg == '0) begin
                gcall <= 1'b1; dir <= 1'b0; sda_oe <= 1'b1; st <= S_AACK;
              end else if (shreg[DW-1:1] == own_addr) begin
                access <= 1'b1; dir <= shreg[0]; sda_oe <= 1'b1; st <= S_AACK;
              end else begin
                access <= 1'b0;
                if (rep) done <= 1'b1;
                st <= S_IDLE;
              end
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (dir) begin
                sda_oe    <= ~nb[DW-1];
                shreg     <= {nb[DW-2:0], 1'b1};
                host_byte <= thr_full;
                thr_full  <= 1'b0;
                st        <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
              end
            end
          S_RX:
            if (scl_rise) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(DW)) begin
              rx_hold <= shreg; rxrdy <= 1'b1; sda_oe <= 1'b1; st <= S_RACK;
            end
          S_RACK:
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
            end
          S_TX:
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == CW'(DW)) begin
                sda_oe <= 1'b0; st <= S_TACK;
              end else begin
                sda_oe <= ~shreg[DW-1];
                shreg  <= {shreg[DW-2:0], 1'b1};
              end
            end
          S_TACK:
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (host_byte && !thr_full) txrdy <= 1'b1;
              host_byte <= 1'b0;
              cnt <= '0;
              if (mack) begin
                sda_oe    <= ~nb[DW-1];
                shreg     <= {nb[DW-2:0], 1'b1};
                host_byte <= thr_full;
                thr_full  <= 1'b0;
                st        <= S_TX;
              end else begin
                access <= 1'b0; st <= S_IDLE;
              end
            end
          default: ;
        endcase
      end
      if (tx_wr) begin
        thr <= tx_data; thr_full <= 1'b1; txrdy <= 1'b0;
      end
    end

  assign rx_data = rx_hold;
  assign status  = {gcall, access, dir, txrdy, rxrdy, done};
endmodule

// File: rtl/i2c_target_stat_chk.sv
module i2c_target_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       tx_wr,
  input logic       rx_rd,
  input logic [5:0] status
);
  // R12
  sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R8
  txrdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !status[2]);

  // R7
  rxrdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> !status[1]);

  // R6
  rx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> sda_oe);

  // R11
  done_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !status[4]);
endmodule

bind i2c_target_stat i2c_target_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .tx_wr(tx_wr), .rx_rd(rx_rd), .status(status)
);

// File: tb/test_i2c_target_stat.sv
module test_i2c_target_stat;
  localparam int Q = 5;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic [5:0] status;
  wire sda_line = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, viol = 0;
  logic [7:0] exp_q[$];
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  i2c_target_stat i_i2c_target_stat (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .rx_data(rx_data), .status(status)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic put_bit(logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~ack);
  endtask

  task automatic host_write(logic [7:0] d);
    tx_data = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic send_data(logic [7:0] d, string req);
    logic ack;
    exp_q.push_back(d);
    wr_byte(d, ack);
    chk(req, ack, 1);
  endtask

  // scoreboard monitor: pops expected bytes as rx-ready rises (R6, R7)
  initial forever begin
    @(negedge clk);
    if (rst_n && status[1] && !rx_rd) begin
      if (exp_q.size() == 0) chk("R6 unexpected byte", rx_data, 32'hFFFF_FFFF);
      else chk("R6 rx byte", rx_data, exp_q.pop_front());
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
      chk("R7 rx-ready cleared", status[1], 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    wq(4);
    chk("R1 reset status", status, 6'b000101);
    chk("R1 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    wq(4);

    // write transfer
    bus_start();
    chk("R2 done clears on start", status[0], 0);
    wr_byte({OWN, 1'b0}, ack);
    chk("R3 address ack", ack, 1);
    chk("R3 addressed set", status[4], 1);
    chk("R3 direction write", status[3], 0);
    send_data(8'hA5, "R6 ack data A5");
    send_data(8'h3C, "R6 ack data 3C");
    bus_stop(); wq(4);
    chk("R2 done sets on stop", status[0], 1);
    chk("R11 addressed cleared by stop", status[4], 0);

    // read transfer with loaded byte, then empty holding register
    host_write(8'h96);
    chk("R8 tx-ready low after write", status[2], 0);
    bus_start();
    wr_byte({OWN, 1'b1}, ack);
    chk("R3 read address ack", ack, 1);
    chk("R3 direction read", status[3], 1);
    rd_byte(d, 1'b1);
    chk("R9 loaded byte sent", d, 8'h96);
    chk("R8 tx-ready after ack", status[2], 1);
    rd_byte(d, 1'b0);
    chk("R9 empty sends FF", d, 8'hFF);
    chk("R10 addressed cleared by nack", status[4], 0);
    host_write(8'h11);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin logic b; get_bit(b); d[7-i] = b; end
    chk("R10 no drive after nack", d, 8'hFF);
    bus_stop(); wq(4);
    chk("R10 byte still held", status[2], 0);
    bus_start();
    wr_byte({OWN, 1'b1}, ack);
    rd_byte(d, 1'b0);
    chk("R10 held byte sent next read", d, 8'h11);
    chk("R8 tx-ready after nack answer", status[2], 1);
    bus_stop(); wq(4);

    // other address
    bus_start();
    wr_byte({7'h55, 1'b0}, ack);
    chk("R4 no ack for other address", ack, 0);
    chk("R4 addressed stays clear", status[4], 0);
    chk("R4 done stays clear after plain start", status[0], 0);
    bus_stop(); wq(4);

    // repeated start to another target
    bus_start();
    wr_byte({OWN, 1'b0}, ack);
    send_data(8'h7E, "R6 ack data 7E");
    bus_start();
    chk("R2 done clears on repeated start", status[0], 0);
    chk("R4 addressed held across repeated start", status[4], 1);
    wr_byte({7'h12, 1'b0}, ack);
    chk("R4 no ack after repeated start", ack, 0);
    chk("R4 addressed cleared", status[4], 0);
    chk("R4 done set on re-address", status[0], 1);
    bus_stop(); wq(4);

    // general call
    bus_start();
    wr_byte(8'h00, ack);
    chk("R5 general call ack", ack, 1);
    chk("R5 general call flag", status[5], 1);
    chk("R5 addressed stays clear", status[4], 0);
    send_data(8'h5A, "R5 general call data ack");
    bus_stop(); wq(4);
    chk("R5 general call flag cleared", status[5], 0);

    wq(20);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    chk("R12 sda changes only with scl low", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule